// File: doc/BRIEF.md
# Serial ADC Post-Conversion Readout Controller

This block sits on the host side of a successive-approximation converter whose serial port is clocked by the host. On a start request it drives the converter's active-low convert strobe for a fixed number of cycles. It then follows the converter's busy line through its low phase (converting) and back to high (finished). Only after busy has returned high does it assert the active-low chip select and generate the serial clock. It shifts in the word that the converter has just produced.

The serial clock rests low. The controller samples the data line on every rising edge that it generates, and leaves a half-period of setup between chip select falling and the first rising edge. Twelve bits are read, most significant first, and presented as a signed two's-complement result with a one-cycle valid strobe. If busy stays in one state too long in either wait phase, a sticky error flag is raised and the controller returns to idle without reading. The busy input passes through a synchronizer before the state machine uses it.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held and after its release, idle is 1, the convert strobe and chip select are 1, the serial clock is 0, and result_valid and timeout_err are 0.
- R2: A start seen in idle drives the convert strobe low for exactly CONV_LOW_CYC clock cycles. Exactly one such pulse is issued per accepted start.
- R3: No serial clock edge occurs while the converter's busy line is low. Reading begins only after busy has been seen low and then high again.
- R4: Chip select is 0 only from the detection of busy returning high until the read ends. The serial clock is high only while chip select is 0.
- R5: The serial clock rests at 0. Its high and low phases each last SCLK_HALF cycles. The first rising edge comes SCLK_HALF cycles after chip select falls, and each read has exactly 12 rising edges.
- R6: The data line is sampled at each generated rising edge, first bit = bit 11 (MSB). The result is the 12-bit two's-complement word so assembled.
- R7: result_valid is a one-cycle pulse, issued in the same cycle that chip select returns to 1. The result holds its value until the next pulse.
- R8: If busy does not fall, or does not rise, within TIMEOUT_CYC cycles of its wait phase, timeout_err becomes 1 and the block returns to idle with no serial clock and no result_valid. timeout_err clears when the next start is accepted.
- R9: idle is 1 only when no transaction is in progress. A start during a transaction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion and readout |
| adc_busy | input | 1 | Converter busy line, low while converting (asynchronous) |
| adc_sdata | input | 1 | Converter serial data output |
| adc_conv_n | output | 1 | Active-low convert strobe |
| adc_cs_n | output | 1 | Active-low chip select enabling the data output |
| adc_sclk | output | 1 | Serial clock generated for the converter |
| result | output | DATA_W | Signed conversion result |
| result_valid | output | 1 | One-cycle strobe, result updated |
| idle | output | 1 | Controller ready for start |
| timeout_err | output | 1 | Sticky busy-timeout flag |

## Verification
A state machine stuck in a wait phase shows up as idle staying low. After TIMEOUT_CYC cycles it appears as timeout_err when no error was expected. A wrong bit counter or phase counter changes the number of serial clock edges, or the high-phase width, within the same read. It therefore corrupts the result on the very next valid strobe. A chip select released early or late is caught within one cycle, because result_valid must coincide with its rising edge.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CONV    = 3'd1,
    ST_WAIT_LO = 3'd2,
    ST_WAIT_HI = 3'd3,
    ST_SHIFT   = 3'd4,
    ST_DONE    = 3'd5
  } rd_state_t;
endpackage

// File: rtl/adc_rd_cnt.sv
// Cycle counter: hit is high in the cycle where the LIMIT-th enabled count ends.
module adc_rd_cnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign hit = en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= hit ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/adc_rd_shreg.sv
// MSB-first serial-in shift register.
module adc_rd_shreg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int CONV_LOW_CYC = 8,
  parameter int SCLK_HALF    = 2,
  parameter int TIMEOUT_CYC  = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     adc_busy,
  input  logic                     adc_sdata,
  output logic                     adc_conv_n,
  output logic                     adc_cs_n,
  output logic                     adc_sclk,
  output logic signed [DATA_W-1:0] result,
  output logic                     result_valid,
  output logic                     idle,
  output logic                     timeout_err
);
  localparam int BIT_W = $clog2(DATA_W);

  rd_state_t state;
  logic [SYNC_STAGES-1:0] busy_sync;
  logic busy_s;
  logic [BIT_W-1:0] bit_cnt;
  logic [DATA_W-1:0] sh_q;

  logic conv_en, conv_clr, conv_hit;
  logic in_wait, tmo_clr, tmo_hit;
  logic ph_en, ph_clr, ph_hit;
  logic sh_en;

  // busy synchronizer
  always_ff @(posedge clk) begin
    if (rst) busy_sync <= '1;
    else     busy_sync <= {busy_sync[SYNC_STAGES-2:0], adc_busy};
  end
  assign busy_s = busy_sync[SYNC_STAGES-1];

  // convert strobe width
  assign conv_en  = (state == ST_CONV);
  assign conv_clr = !conv_en;
  adc_rd_cnt #(.LIMIT(CONV_LOW_CYC)) u_conv_cnt (
    .clk(clk), .rst(rst), .clr(conv_clr), .en(conv_en), .hit(conv_hit)
  );

  // busy watchdog, restarts in each wait phase
  assign in_wait = (state == ST_WAIT_LO) || (state == ST_WAIT_HI);
  assign tmo_clr = !in_wait || ((state == ST_WAIT_LO) && !busy_s) ||
                   ((state == ST_WAIT_HI) && busy_s);
  adc_rd_cnt #(.LIMIT(TIMEOUT_CYC)) u_tmo_cnt (
    .clk(clk), .rst(rst), .clr(tmo_clr), .en(in_wait), .hit(tmo_hit)
  );

  // serial clock half-period timer
  assign ph_en  = (state == ST_SHIFT);
  assign ph_clr = !ph_en;
  adc_rd_cnt #(.LIMIT(SCLK_HALF)) u_ph_cnt (
    .clk(clk), .rst(rst), .clr(ph_clr), .en(ph_en), .hit(ph_hit)
  );

  // sample on the edge that raises the serial clock
  assign sh_en = ph_hit && !adc_sclk;
  adc_rd_shreg #(.W(DATA_W)) u_shreg (
    .clk(clk), .rst(rst), .en(sh_en), .din(adc_sdata), .q(sh_q)
  );

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      adc_conv_n   <= 1'b1;
      adc_cs_n     <= 1'b1;
      adc_sclk     <= 1'b0;
      bit_cnt      <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      timeout_err  <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          adc_conv_n  <= 1'b0;
          timeout_err <= 1'b0;
          bit_cnt     <= '0;
          state       <= ST_CONV;
        end
        ST_CONV: if (conv_hit) begin
          adc_conv_n <= 1'b1;
          state      <= ST_WAIT_LO;
        end
        ST_WAIT_LO: begin
          if (!busy_s) state <= ST_WAIT_HI;
          else if (tmo_hit) begin
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        ST_WAIT_HI: begin
          if (busy_s) begin
            adc_cs_n <= 1'b0;
            state    <= ST_SHIFT;
          end else if (tmo_hit) begin
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        ST_SHIFT: if (ph_hit) begin
          if (!adc_sclk) adc_sclk <= 1'b1;
          else begin
            adc_sclk <= 1'b0;
            if (bit_cnt == BIT_W'(DATA_W - 1)) state <= ST_DONE;
            else bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_DONE: begin
          result       <= signed'(sh_q);
          result_valid <= 1'b1;
          adc_cs_n     <= 1'b1;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     adc_conv_n,
  input logic                     adc_cs_n,
  input logic                     adc_sclk,
  input logic signed [DATA_W-1:0] result,
  input logic                     result_valid,
  input logic                     idle,
  input logic                     timeout_err
);
  a_r2_conv_from_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_conv_n) |-> $past(idle));
  a_r9_conv_not_idle: assert property (@(posedge clk) disable iff (rst)
    !adc_conv_n |-> !idle);
  a_r3_no_read_in_conv: assert property (@(posedge clk) disable iff (rst)
    !adc_conv_n |-> (adc_cs_n && !adc_sclk));
  a_r4_sclk_needs_cs: assert property (@(posedge clk) disable iff (rst)
    adc_sclk |-> !adc_cs_n);
  a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
  a_r7_valid_with_cs_release: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $rose(adc_cs_n));
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(result));
  a_r8_err_returns_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> (idle && adc_cs_n));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .adc_conv_n(adc_conv_n), .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk), .result(result), .result_valid(result_valid),
  .idle(idle), .timeout_err(timeout_err)
);

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;
  localparam int DW = 12;
  localparam int CONV_LOW = 8;
  localparam int HALF = 2;
  localparam int TMO = 100;
  localparam int M_NONE = 0, M_NORMAL = 1, M_STUCK = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, busy = 1'b1, sdata = 1'b0;
  logic conv_n, cs_n, sclk, result_valid, idle, timeout_err;
  logic signed [DW-1:0] result;

  int n_chk = 0, n_fail = 0;
  int mode = M_NORMAL;
  logic [DW-1:0] cur_word = '0;
  int bit_idx = 0;

  always #2.5 clk = ~clk;

  adc_rd_ctrl #(.DATA_W(DW), .CONV_LOW_CYC(CONV_LOW), .SCLK_HALF(HALF),
                .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .start(start), .adc_busy(busy), .adc_sdata(sdata),
    .adc_conv_n(conv_n), .adc_cs_n(cs_n), .adc_sclk(sclk), .result(result),
    .result_valid(result_valid), .idle(idle), .timeout_err(timeout_err)
  );

  // converter model
  always @(negedge conv_n) begin
    if (mode != M_NONE) begin
      #20 busy = 1'b0;
      if (mode == M_NORMAL) begin
        #300 busy = 1'b1;
      end
    end
  end
  always @(negedge cs_n) begin
    bit_idx = 0;
    sdata = cur_word[DW-1];
  end
  always @(posedge sclk) begin
    #1;
    bit_idx++;
    if (bit_idx < DW) sdata = cur_word[DW-1-bit_idx];
  end

  // port monitors, sampled at the falling clock edge
  int cyc = 0, conv_low_cnt = 0, conv_falls = 0, sclk_rises = 0, rise_busy_low = 0;
  int cs_falls = 0, cs_fall_cyc = 0, first_rise_cyc = 0, sclk_high_cnt = 0, valid_cnt = 0;
  logic p_conv = 1'b1, p_cs = 1'b1, p_sclk = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!conv_n) conv_low_cnt++;
    if (p_conv && !conv_n) conv_falls++;
    if (p_cs && !cs_n) begin cs_falls++; cs_fall_cyc = cyc; end
    if (!p_sclk && sclk) begin
      if (sclk_rises == 0) first_rise_cyc = cyc;
      sclk_rises++;
      if (!busy) rise_busy_low++;
    end
    if (sclk) sclk_high_cnt++;
    if (result_valid) valid_cnt++;
    p_conv = conv_n; p_cs = cs_n; p_sclk = sclk;
  end

  task automatic clear_mon();
    conv_low_cnt = 0; conv_falls = 0; sclk_rises = 0; rise_busy_low = 0;
    cs_falls = 0; sclk_high_cnt = 0; valid_cnt = 0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(idle && conv_n && cs_n && !sclk && !result_valid && !timeout_err,
        "R1", "outputs in reset", {idle, conv_n, cs_n, sclk, result_valid, timeout_err}, 6'b111000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(idle && conv_n && cs_n && !sclk && !result_valid && !timeout_err,
        "R1", "outputs after reset", {idle, conv_n, cs_n, sclk, result_valid, timeout_err}, 6'b111000);
  endtask

  task automatic t_read(input logic [DW-1:0] word, input bit extra_start);
    bit sent = 0;
    cur_word = word;
    mode = M_NORMAL;
    @(negedge clk);
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!idle, "R9", "idle during transaction", idle, 0);
    chk(!timeout_err, "R8", "error cleared by start", timeout_err, 0);
    for (int i = 0; i < 3000 && !result_valid; i++) begin
      @(negedge clk);
      if (extra_start && !sent && !busy && !result_valid) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sent = 1;
      end
    end
    chk(result_valid == 1'b1, "R7", "valid strobe seen", result_valid, 1);
    chk(12'(result) == word, "R6", "result word", int'(12'(result)), int'(word));
    chk(cs_n == 1'b1, "R7", "cs released with valid", cs_n, 1);
    chk(conv_low_cnt == CONV_LOW, "R2", "convert low cycles", conv_low_cnt, CONV_LOW);
    chk(conv_falls == 1, "R2", "one convert pulse (R9 start ignored)", conv_falls, 1);
    chk(sclk_rises == DW, "R5", "rising edges", sclk_rises, DW);
    chk(first_rise_cyc - cs_fall_cyc == HALF, "R5", "setup before first edge",
        first_rise_cyc - cs_fall_cyc, HALF);
    chk(sclk_high_cnt == DW * HALF, "R5", "high phase total", sclk_high_cnt, DW * HALF);
    chk(rise_busy_low == 0, "R3", "edges while busy low", rise_busy_low, 0);
    chk(cs_falls == 1, "R4", "one chip select window", cs_falls, 1);
    @(negedge clk);
    chk(!result_valid, "R7", "valid one cycle", result_valid, 0);
    chk(idle, "R9", "back to idle", idle, 1);
    repeat (10) @(negedge clk);
    chk(12'(result) == word, "R7", "result held", int'(12'(result)), int'(word));
  endtask

  task automatic t_timeout(input int m, input string tag);
    mode = m;
    @(negedge clk);
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 1000 && !timeout_err; i++) @(negedge clk);
    chk(timeout_err == 1'b1, "R8", {tag, " error flag"}, timeout_err, 1);
    chk(idle == 1'b1, "R8", {tag, " back to idle"}, idle, 1);
    chk(sclk_rises == 0, "R8", {tag, " no serial clock"}, sclk_rises, 0);
    chk(cs_falls == 0, "R8", {tag, " chip select untouched"}, cs_falls, 0);
    chk(valid_cnt == 0, "R8", {tag, " no valid"}, valid_cnt, 0);
    repeat (20) @(negedge clk);
    chk(timeout_err == 1'b1, "R8", {tag, " flag sticky"}, timeout_err, 1);
    busy = 1'b1;
    mode = M_NORMAL;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_read(12'h7FF, 1'b0);
    t_read(12'h800, 1'b0);
    t_read(12'hA5C, 1'b1);
    t_timeout(M_NONE, "busy never falls");
    t_read(12'h001, 1'b0);
    t_timeout(M_STUCK, "busy never rises");
    t_read(12'hFFF, 1'b0);
    t_read(12'h3C6, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule